// File: doc/BRIEF.md
# Section Translation Cache

This block keeps the most recent section translations so that a translated access does not need fresh table reads. A section covers one megabyte: the upper 12 bits of a 32-bit virtual address form the tag, and the lower 20 bits pass through to the physical address unchanged. A lookup that matches a valid entry returns the replacement upper bits, the domain number and the cacheable and bufferable attributes in the same cycle. A lookup that matches nothing raises a walk request. The walker then writes its result back through the refill port.

The domain number from a hit is checked against the live domain control word. Rewriting that word therefore takes effect on the next lookup, and no flush is needed. Any edit to the translation table requires a full flush, and so does the start of operation. A one-cycle busy flag and a done pulse let barrier logic hold translation until the flush has finished.

Top module: `section_xlat_cache`

## Requirements
- R1: Out of reset no entry is valid, and `lookupHit`, `walkReq`, `invBusy` and `invDone` are all low.
- R2: Suppose `lookupValid` is high, no flush is active, and bits 31:20 of `lookupVaddr` equal the tag of a valid entry. Then `lookupHit` is high in the same cycle and `physAddr` is the entry's 12-bit base followed by bits 19:0 of `lookupVaddr`. Without a hit, `physAddr` is zero.
- R3: Suppose `lookupValid` is high, no flush is active, and no valid entry matches. Then `walkReq` is high and `lookupHit` is low. The two outputs are never high together.
- R4: On a hit, `hitDomain`, `hitCacheable` and `hitBufferable` carry the domain and the C and B bits that were stored with the entry. Without a hit, all three are zero.
- R5: The cache has 8 entries. Refills with new tags fill slots 0 to 7 in round-robin order, so a ninth new tag replaces the oldest allocation.
- R6: A refill whose tag is already present overwrites that entry and does not advance the round-robin pointer, so no duplicate tag can exist.
- R7: `invReq` sampled high at a clock edge clears every entry and resets the round-robin pointer to slot 0 at that edge. `invBusy` is then high during the next cycle.
- R8: In a cycle where `invReq` or `invBusy` is high, `lookupHit` and `walkReq` stay low and a refill is ignored.
- R9: `invDone` is high for exactly one cycle, the cycle right after the last busy cycle. No new `invReq` may be present in that busy cycle.
- R10: On a hit with domain d, the 2-bit field `domainCtrl[2d+1:2d]` selects the outcome. The value 00 or 10 raises `domainFault`. The value 01 raises `permCheck`. The value 11 raises neither. The current value of `domainCtrl` is used, and no flush is needed after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Translation lookup request |
| lookupVaddr | input | 32 | Virtual address to translate |
| domainCtrl | input | 32 | Sixteen 2-bit domain access fields |
| lookupHit | output | 1 | Lookup matched a valid entry |
| walkReq | output | 1 | Lookup missed; a table walk is needed |
| physAddr | output | 32 | Translated address on a hit, zero otherwise |
| hitDomain | output | 4 | Domain number of the hit entry |
| hitCacheable | output | 1 | C attribute of the hit entry |
| hitBufferable | output | 1 | B attribute of the hit entry |
| domainFault | output | 1 | The hit's domain forbids the access |
| permCheck | output | 1 | The hit's domain needs an access-permission check |
| refillValid | input | 1 | Walk result is present |
| refillTag | input | 12 | Virtual section index of the walk result |
| refillBase | input | 12 | Physical section base of the walk result |
| refillDomain | input | 4 | Domain of the walk result |
| refillCacheable | input | 1 | C attribute of the walk result |
| refillBufferable | input | 1 | B attribute of the walk result |
| invReq | input | 1 | Flush all entries |
| invBusy | output | 1 | Flush in progress |
| invDone | output | 1 | Flush finished |

## Verification
The assertions expect every input to carry a known value after reset. They also expect `invReq` to be a request that the control logic samples at each edge, not a level that has to be held. The no-duplicate check assumes that tags enter the cache only through the refill port, and that a refill carrying a tag already present is a normal event. The stimulus always drives defined values, keeps its random tags within sixteen sections so that both overwrites and evictions occur often, and sends flush requests as single pulses as well as back-to-back ones.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

  // Strobes from the control path to the entry storage
  typedef struct packed {
    logic clearAll;       // drop every entry, rewind the victim pointer
    logic writeEn;        // store the refill data this cycle
    logic advanceVictim;  // refill took a fresh slot
    logic blockLookup;    // flush in flight: no hit, no walk
  } ctrlStrobes_t;

endpackage

// File: rtl/sxc_ctrl.sv
module sxc_ctrl
  import sxc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         invReq,
  input  logic         refillValid,
  input  logic         refillMatch,
  output ctrlStrobes_t strobes,
  output logic         invBusy,
  output logic         invDone
);

  logic busyQ;
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      busyQ <= invReq;
      doneQ <= busyQ && !invReq;
    end
  end

  always_comb begin
    strobes.clearAll      = invReq;
    strobes.blockLookup   = invReq || busyQ;
    strobes.writeEn       = refillValid && !(invReq || busyQ);
    strobes.advanceVictim = strobes.writeEn && !refillMatch;
  end

  assign invBusy = busyQ;
  assign invDone = doneQ;

  // R7
  busy_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    invReq |=> invBusy);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    invDone |-> ($past(invBusy) && !invBusy));
  // R8
  no_write_when_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    invBusy |-> !strobes.writeEn);

endmodule

// File: rtl/sxc_datapath.sv
module sxc_datapath
  import sxc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 12,
  parameter int DOM_W   = 4
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic [TAG_W-1:0] refillTag,
  input  logic [TAG_W-1:0] refillBase,
  input  logic [DOM_W-1:0] refillDom,
  input  logic             refillC,
  input  logic             refillB,
  output logic             rawHit,
  output logic [TAG_W-1:0] hitBase,
  output logic [DOM_W-1:0] hitDom,
  output logic             hitC,
  output logic             hitB,
  output logic             refillMatch
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [TAG_W-1:0]   baseQ [ENTRIES];
  logic [DOM_W-1:0]   domQ  [ENTRIES];
  logic [ENTRIES-1:0] cQ;
  logic [ENTRIES-1:0] bQ;
  logic [PTR_W-1:0]   victimQ;

  logic [ENTRIES-1:0] lookVec;
  logic [ENTRIES-1:0] fillVec;
  logic [ENTRIES-1:0] wrSel;

  // one tag comparator pair per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lookVec[g] = validQ[g] && (tagQ[g] == lookupTag);
    assign fillVec[g] = validQ[g] && (tagQ[g] == refillTag);
    assign wrSel[g]   = refillMatch ? fillVec[g] : (victimQ == PTR_W'(g));
  end

  assign refillMatch = |fillVec;
  assign rawHit      = |lookVec;

  // one-hot read mux
  always_comb begin
    hitBase = '0;
    hitDom  = '0;
    hitC    = 1'b0;
    hitB    = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookVec[i]) begin
        hitBase = hitBase | baseQ[i];
        hitDom  = hitDom | domQ[i];
        hitC    = hitC | cQ[i];
        hitB    = hitB | bQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobes.clearAll) begin
      validQ <= '0;
    end else if (strobes.writeEn) begin
      validQ <= validQ | wrSel;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strobes.writeEn && wrSel[i]) begin
        tagQ[i]  <= refillTag;
        baseQ[i] <= refillBase;
        domQ[i]  <= refillDom;
        cQ[i]    <= refillC;
        bQ[i]    <= refillB;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      victimQ <= '0;
    end else if (strobes.advanceVictim) begin
      victimQ <= (victimQ == LAST_SLOT) ? '0 : victimQ + 1'b1;
    end
  end

  // R6
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookVec) && $onehot0(fillVec));
  // R7
  cleared_after_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (validQ == '0));

endmodule

// File: rtl/section_xlat_cache.sv
module section_xlat_cache
  import sxc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int TAG_W   = 12,
  parameter int DOM_W   = 4
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lookupValid,
  input  logic [VA_W-1:0]           lookupVaddr,
  input  logic [2*(2**DOM_W)-1:0]   domainCtrl,
  output logic                      lookupHit,
  output logic                      walkReq,
  output logic [VA_W-1:0]           physAddr,
  output logic [DOM_W-1:0]          hitDomain,
  output logic                      hitCacheable,
  output logic                      hitBufferable,
  output logic                      domainFault,
  output logic                      permCheck,
  input  logic                      refillValid,
  input  logic [TAG_W-1:0]          refillTag,
  input  logic [TAG_W-1:0]          refillBase,
  input  logic [DOM_W-1:0]          refillDomain,
  input  logic                      refillCacheable,
  input  logic                      refillBufferable,
  input  logic                      invReq,
  output logic                      invBusy,
  output logic                      invDone
);

  localparam int OFF_W = VA_W - TAG_W;

  ctrlStrobes_t     strobes;
  logic             refillMatch;
  logic             rawHit;
  logic [TAG_W-1:0] rawBase;
  logic [DOM_W-1:0] rawDom;
  logic             rawC;
  logic             rawB;
  logic [1:0]       domField;

  sxc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .invReq      (invReq),
    .refillValid (refillValid),
    .refillMatch (refillMatch),
    .strobes     (strobes),
    .invBusy     (invBusy),
    .invDone     (invDone)
  );

  sxc_datapath #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .DOM_W   (DOM_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .lookupTag   (lookupVaddr[VA_W-1:OFF_W]),
    .refillTag   (refillTag),
    .refillBase  (refillBase),
    .refillDom   (refillDomain),
    .refillC     (refillCacheable),
    .refillB     (refillBufferable),
    .rawHit      (rawHit),
    .hitBase     (rawBase),
    .hitDom      (rawDom),
    .hitC        (rawC),
    .hitB        (rawB),
    .refillMatch (refillMatch)
  );

  always_comb begin
    lookupHit     = lookupValid && !strobes.blockLookup && rawHit;
    walkReq       = lookupValid && !strobes.blockLookup && !rawHit;
    physAddr      = lookupHit ? {rawBase, lookupVaddr[OFF_W-1:0]} : '0;
    hitDomain     = lookupHit ? rawDom : '0;
    hitCacheable  = lookupHit && rawC;
    hitBufferable = lookupHit && rawB;
    domField      = domainCtrl[2*rawDom +: 2];
    domainFault   = lookupHit && !domField[0];
    permCheck     = lookupHit && (domField == 2'b01);
  end

  // R3
  hit_walk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lookupHit && walkReq));
  // R8
  quiet_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    invBusy |-> (!lookupHit && !walkReq));
  // R7
  empty_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    invBusy |=> !lookupHit);
  // R10
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (domainFault || permCheck) |-> (lookupHit && !(domainFault && permCheck)));

endmodule

// File: tb/test_section_xlat_cache.sv
`timescale 1ns/1ps
module test_section_xlat_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic [31:0] domainCtrl = '1;
  logic        lookupHit, walkReq, hitCacheable, hitBufferable, domainFault, permCheck;
  logic [31:0] physAddr;
  logic [3:0]  hitDomain;
  logic        refillValid = 1'b0;
  logic [11:0] refillTag = '0, refillBase = '0;
  logic [3:0]  refillDomain = '0;
  logic        refillCacheable = 1'b0, refillBufferable = 1'b0;
  logic        invReq = 1'b0;
  logic        invBusy, invDone;

  always #10 clk = ~clk;  // 50 MHz

  section_xlat_cache i_section_xlat_cache (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .domainCtrl(domainCtrl), .lookupHit(lookupHit), .walkReq(walkReq),
    .physAddr(physAddr), .hitDomain(hitDomain), .hitCacheable(hitCacheable),
    .hitBufferable(hitBufferable), .domainFault(domainFault), .permCheck(permCheck),
    .refillValid(refillValid), .refillTag(refillTag), .refillBase(refillBase),
    .refillDomain(refillDomain), .refillCacheable(refillCacheable),
    .refillBufferable(refillBufferable), .invReq(invReq), .invBusy(invBusy),
    .invDone(invDone)
  );

  int vectors = 0;
  int errors = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit        mValid [8];
  int        mTag [8], mBase [8], mDom [8], mC [8], mB [8];
  int        mPtr;
  bit        mBusy, mDone;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mValid[i] = 0;
      mPtr = 0; mBusy = 0; mDone = 0;
    end else begin
      bit blk;
      blk = invReq || mBusy;
      if (invReq) begin
        for (int i = 0; i < 8; i++) mValid[i] = 0;
        mPtr = 0;
      end else if (!blk && refillValid) begin
        int slot;
        slot = -1;
        for (int i = 0; i < 8; i++) if (mValid[i] && mTag[i] == refillTag) slot = i;
        if (slot < 0) begin
          slot = mPtr;
          mPtr = (mPtr + 1) % 8;
        end
        mValid[slot] = 1; mTag[slot] = refillTag; mBase[slot] = refillBase;
        mDom[slot] = refillDomain; mC[slot] = refillCacheable; mB[slot] = refillBufferable;
      end
      mDone = mBusy && !invReq;
      mBusy = invReq;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      int idx, fld;
      bit blk, eHit, eWalk;
      longint ePa;
      blk = invReq || mBusy;
      idx = -1;
      for (int i = 0; i < 8; i++) if (mValid[i] && mTag[i] == lookupVaddr[31:20]) idx = i;
      eHit = lookupValid && !blk && idx >= 0;
      eWalk = lookupValid && !blk && idx < 0;
      check("R2", "hit", lookupHit, eHit);
      check("R3", "walk", walkReq, eWalk);
      check("R7", "busy", invBusy, mBusy);
      check("R9", "done", invDone, mDone);
      if (eHit) begin
        ePa = (longint'(mBase[idx]) << 20) | lookupVaddr[19:0];
        fld = (domainCtrl >> (2 * mDom[idx])) & 3;
        check("R2", "paddr", physAddr, ePa);
        check("R4", "domain", hitDomain, mDom[idx]);
        check("R4", "C", hitCacheable, mC[idx]);
        check("R4", "B", hitBufferable, mB[idx]);
        check("R10", "fault", domainFault, (fld == 0 || fld == 2));
        check("R10", "client", permCheck, (fld == 1));
      end else begin
        check("R2", "paddr", physAddr, 0);
        check("R4", "attrs", {hitDomain, hitCacheable, hitBufferable}, 0);
        check("R10", "fault", {domainFault, permCheck}, 0);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    refillValid = 0; invReq = 0; lookupValid = 0;
  endtask

  task automatic fill(input int tag, input int base, input int dom, input int cb);
    refillValid = 1; refillTag = 12'(tag); refillBase = 12'(base);
    refillDomain = 4'(dom); refillCacheable = cb[0]; refillBufferable = cb[1];
    step();
  endtask

  task automatic look(input int tag);
    lookupValid = 1; lookupVaddr = {12'(tag), 20'h0ABCD};
  endtask

  // lookup and sample at the falling edge of the same cycle
  task automatic probe(input int tag, input string req, input bit expHit);
    look(tag);
    @(negedge clk);
    check(req, "probe hit", lookupHit, expHit);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R1", "reset hit/walk/busy/done", {lookupHit, walkReq, invBusy, invDone}, 0);
    rstN = 1;
    step();
    look(12'h123);
    @(negedge clk);
    check("R1", "empty after reset", {lookupHit, walkReq}, 2'b01);
    step();

    for (int i = 0; i < 8; i++) fill(12'h100 + i, 12'h400 + 3 * i, i, i % 4);
    for (int i = 0; i < 8; i++) probe(12'h100 + i, "R2", 1);

    fill(12'h108, 12'h7F0, 5, 3);
    probe(12'h100, "R5", 0);
    probe(12'h101, "R5", 1);
    probe(12'h108, "R5", 1);

    fill(12'h103, 12'hABC, 9, 1);
    probe(12'h103, "R6", 1);
    fill(12'h109, 12'h111, 2, 0);
    probe(12'h102, "R6", 1);
    probe(12'h101, "R6", 0);

    domainCtrl = 32'h0000_00E4;
    for (int i = 2; i < 8; i++) probe(12'h100 + i, "R10", 1);
    domainCtrl = 32'hFFFF_FF1B;
    for (int i = 2; i < 8; i++) probe(12'h100 + i, "R10", 1);
    domainCtrl = '1;

    invReq = 1; look(12'h102); refillValid = 1; refillTag = 12'h1AA;
    @(negedge clk);
    check("R8", "hit during request", {lookupHit, walkReq}, 0);
    step();
    look(12'h102); refillValid = 1; refillTag = 12'h1AB;
    @(negedge clk);
    check("R8", "hit while busy", {lookupHit, walkReq}, 0);
    step();
    probe(12'h1AB, "R8", 0);
    probe(12'h102, "R7", 0);

    invReq = 1; step();
    invReq = 1; step();
    step();
    step();
    for (int i = 0; i < 9; i++) fill(12'h200 + i, 12'h300 + i, 15 - i, 2);
    probe(12'h200, "R7", 0);
    probe(12'h201, "R7", 1);

    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom % 100;
      lookupValid = ($urandom % 4) != 0;
      lookupVaddr = {12'h100 + 12'($urandom % 16), 20'($urandom)};
      if (r < 4) invReq = 1;
      if (r >= 4 && r < 40) begin
        refillValid = 1; refillTag = 12'h100 + 12'($urandom % 16);
        refillBase = 12'($urandom); refillDomain = 4'($urandom);
        refillCacheable = 1'($urandom); refillBufferable = 1'($urandom);
      end
      if (r == 99) domainCtrl = $urandom;
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule